// File: doc/BRIEF.md
# Module Identification Store with Two-Wire Slave

This block is a two-wire serial slave that holds the 256-byte identification store of a memory module. A host on the shared bus can read the module's organisation and timing bytes from it, and can rewrite single bytes. Three strap inputs set the low bits of the slave address, so several modules can share one bus. Each module answers only when the address it receives matches its own straps.

SCL and SDA reach the block already synchronised to the fast system clock. SDA is open drain: the block pulls the line low through `sda_oe_o` and otherwise leaves it released. After a committed write the block runs a timed program window, and it ignores its own address until that window ends. A monitor sums the first bytes of the store again after reset and after every commit, and it raises a flag when the stored check byte does not match that sum.

Top module: `spd_eeprom_slave`

## Requirements
- R1: The slave address is the 7 bits {1010b, strap_i[2:0]}, followed by the direction bit (1 = read). The block acknowledges a matching address by pulling SDA low in the ninth bit. For any other address it does not drive SDA until the next start condition.
- R2: After reset SDA is released. Byte 00h reads 80h, byte 01h reads 08h, and bytes 24h..3Dh and 40h..FFh read 00h.
- R3: In the reset image, byte 3Fh equals the low 8 bits of the arithmetic sum of bytes 00h..3Eh.
- R4: A random read returns the addressed byte, most significant bit first. The sequence is: write-direction address, word address, repeated start, read-direction address.
- R5: Each byte sent to the host advances the word pointer by one, and the pointer wraps from FFh to 00h. A host NACK followed by a stop ends the read. A later read that sends no word address continues from the pointer.
- R6: A write carries the word address and one data byte. The block acknowledges both, and the byte is stored when the stop condition arrives.
- R7: The block does not acknowledge a second data byte in the same write and discards it. The first byte is still stored at the stop condition.
- R8: A write whose data byte is followed by a repeated start instead of a stop is discarded and starts no program window.
- R9: After a committed write the block does not acknowledge its own address for BUSY_CYCLES clocks. After that window it answers again.
- R10: When wp_i is high at the stop condition, the data byte has still been acknowledged. The store is left unchanged and no program window starts.
- R11: SDA output changes only while SCL is low. A change takes effect HOLD_CYC clocks after the falling edge of SCL is seen, never earlier.
- R12: csum_bad_o is low after reset. It is updated only at the end of each full scan, which runs after reset and after every commit. It is high exactly when byte 3Fh differs from the low 8 bits of the sum of bytes 00h..3Eh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the identification image |
| scl_i | input | 1 | Synchronised serial clock level |
| sda_i | input | 1 | Synchronised serial data level as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Module position straps, low address bits |
| wp_i | input | 1 | Write protect; high blocks commits |
| csum_bad_o | output | 1 | Check byte differs from the computed sum |

## Verification
The hardest state to reach from the ports is the program window. It is only visible as a missing acknowledge, and it lasts just BUSY_CYCLES clocks. The bench therefore probes the slave address straight after the stop that ends a write, and probes it again after the window has run out. The check-byte flag also takes some setting up. The bench writes an inverted value into a byte that the sum covers, waits for the program window and the rescan, checks the flag, and then restores the byte.

// File: rtl/spd_pkg.sv
package spd_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_ACK_DEV,
      ST_WADDR,
      ST_ACK_WADDR,
      ST_WDATA,
      ST_ACK_WDATA,
      ST_RDATA,
      ST_RACK
   } link_state_t;

   // Programmed identification content; unlisted bytes are blank (00h).
   function automatic logic [7:0] base_byte(input int unsigned idx);
      logic [7:0] v;
      case (idx)
         0:       v = 8'h80;
         1:       v = 8'h08;
         2:       v = 8'h07;
         3:       v = 8'h0D;
         4:       v = 8'h09;
         5:       v = 8'h01;
         6:       v = 8'h40;
         8:       v = 8'h04;
         9:       v = 8'h75;
         10:      v = 8'h75;
         12:      v = 8'h82;
         13:      v = 8'h10;
         15:      v = 8'h01;
         16:      v = 8'h0E;
         17:      v = 8'h04;
         18:      v = 8'h0C;
         19:      v = 8'h01;
         20:      v = 8'h02;
         21:      v = 8'h20;
         23:      v = 8'hA0;
         24:      v = 8'h75;
         27:      v = 8'h50;
         28:      v = 8'h3C;
         29:      v = 8'h50;
         30:      v = 8'h2D;
         31:      v = 8'h20;
         32:      v = 8'h90;
         33:      v = 8'h90;
         34:      v = 8'h50;
         35:      v = 8'h50;
         default: v = 8'h00;
      endcase
      return v;
   endfunction

   // Reset image: the check byte holds the 8-bit sum of all bytes below it.
   function automatic logic [7:0] image_byte(input int unsigned idx,
                                             input int unsigned csum_idx);
      logic [7:0] acc;
      acc = 8'h00;
      if (idx == csum_idx) begin
         for (int unsigned k = 0; k < csum_idx; k++) acc = acc + base_byte(k);
         return acc;
      end
      return base_byte(idx);
   endfunction

endpackage

// File: rtl/spd_bus_edge.sv
module spd_bus_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = !scl_q && scl_i;
   assign scl_fall  = scl_q && !scl_i;
   // SDA moving while SCL stays high marks frame boundaries
   assign start_evt = scl_q && scl_i && sda_q && !sda_i;
   assign stop_evt  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/spd_store.sv
module spd_store #(
   parameter int unsigned AW       = 8,
   parameter int unsigned CSUM_IDX = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata,
   input  logic [AW-1:0] saddr,
   output logic [7:0]    sdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [7:0] rows [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      localparam logic [7:0] INIT = spd_pkg::image_byte(i, CSUM_IDX);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       q <= INIT;
         else if (we && waddr == AW'(i))   q <= wdata;
      end
      assign rows[i] = q;
   end

   assign rdata = rows[raddr];
   assign sdata = rows[saddr];
endmodule

// File: rtl/spd_csum_scan.sv
module spd_csum_scan #(
   parameter int unsigned AW       = 8,
   parameter int unsigned CSUM_IDX = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kick,
   input  logic [7:0]    sdata,
   output logic [AW-1:0] saddr,
   output logic          csum_bad,
   output logic          done
);
   localparam logic [AW-1:0] LAST = AW'(CSUM_IDX);

   logic          active;
   logic [AW-1:0] idx;
   logic [7:0]    acc;

   // One byte per clock; the check byte is compared in the final step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b1;
         idx      <= '0;
         acc      <= 8'h00;
         csum_bad <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (kick) begin
            active <= 1'b1;
            idx    <= '0;
            acc    <= 8'h00;
         end else if (active) begin
            if (idx == LAST) begin
               csum_bad <= (acc != sdata);
               done     <= 1'b1;
               active   <= 1'b0;
            end else begin
               acc <= acc + sdata;
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign saddr = idx;
endmodule

// File: rtl/spd_eeprom_slave.sv
module spd_eeprom_slave #(
   parameter int unsigned AW          = 8,
   parameter int unsigned CSUM_IDX    = 63,
   parameter int unsigned BUSY_CYCLES = 500000,
   parameter int unsigned HOLD_CYC    = 10,
   parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_i,
   output logic       csum_bad_o
);
   import spd_pkg::*;

   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned BW    = $clog2(BUSY_CYCLES + 1);

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("AW must lie in 1..8");
   end
   if (CSUM_IDX >= DEPTH) begin : g_bad_csum
      $error("CSUM_IDX must address a byte of the store");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic scl_rise, scl_fall, start_evt, stop_evt;

   spd_bus_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   link_state_t   state;
   logic [2:0]    bit_cnt;
   logic [7:0]    rx_sh;
   logic [7:0]    tx_sh;
   logic [AW-1:0] ptr;
   logic          rd_mode;
   logic          pend_valid;
   logic [AW-1:0] pend_addr;
   logic [7:0]    pend_data;
   logic [BW-1:0] busy_cnt;
   logic          busy;
   logic          mem_we;
   logic [7:0]    rdata;
   logic [AW-1:0] scan_addr;
   logic [7:0]    scan_data;
   logic          scan_done;
   logic          csum_bad;
   logic          drive_next;
   logic          sda_oe_q;
   logic          in_ack_dev;
   logic [7:0]    rx_next;
   logic          byte_done;
   logic          addr_hit;

   assign rx_next    = {rx_sh[6:0], sda_i};
   assign byte_done  = (bit_cnt == 3'd7);
   assign busy       = (busy_cnt != '0);
   assign addr_hit   = (rx_next[7:1] == {DEV_TYPE, strap_i}) && !busy;
   assign mem_we     = stop_evt && pend_valid && !wp_i;
   assign in_ack_dev = (state == ST_ACK_DEV);

   spd_store #(.AW(AW), .CSUM_IDX(CSUM_IDX)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .waddr (pend_addr),
      .wdata (pend_data),
      .raddr (ptr),
      .rdata (rdata),
      .saddr (scan_addr),
      .sdata (scan_data)
   );

   spd_csum_scan #(.AW(AW), .CSUM_IDX(CSUM_IDX)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick     (mem_we),
      .sdata    (scan_data),
      .saddr    (scan_addr),
      .csum_bad (csum_bad),
      .done     (scan_done)
   );

   // Link state machine: bits are taken on SCL rise, frames on start/stop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= 3'd0;
         rx_sh      <= 8'h00;
         tx_sh      <= 8'h00;
         ptr        <= '0;
         rd_mode    <= 1'b0;
         pend_valid <= 1'b0;
         pend_addr  <= '0;
         pend_data  <= 8'h00;
      end else if (start_evt) begin
         state      <= ST_DEV;
         bit_cnt    <= 3'd0;
         pend_valid <= 1'b0;
      end else if (stop_evt) begin
         state      <= ST_IDLE;
         pend_valid <= 1'b0;
      end else if (scl_rise) begin
         case (state)
            ST_DEV: begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) begin
                  if (addr_hit) begin
                     state   <= ST_ACK_DEV;
                     rd_mode <= rx_next[0];
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK_DEV: begin
               bit_cnt <= 3'd0;
               if (rd_mode) begin
                  state <= ST_RDATA;
                  tx_sh <= rdata;
                  ptr   <= ptr + 1'b1;
               end else begin
                  state <= ST_WADDR;
               end
            end
            ST_WADDR: begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) begin
                  ptr   <= rx_next[AW-1:0];
                  state <= ST_ACK_WADDR;
               end
            end
            ST_ACK_WADDR: begin
               bit_cnt <= 3'd0;
               state   <= ST_WDATA;
            end
            ST_WDATA: begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) begin
                  if (!pend_valid) begin
                     pend_valid <= 1'b1;
                     pend_addr  <= ptr;
                     pend_data  <= rx_next;
                     ptr        <= ptr + 1'b1;
                     state      <= ST_ACK_WDATA;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_ACK_WDATA: begin
               bit_cnt <= 3'd0;
               state   <= ST_WDATA;
            end
            ST_RDATA: begin
               tx_sh   <= {tx_sh[6:0], 1'b0};
               bit_cnt <= bit_cnt + 3'd1;
               if (byte_done) state <= ST_RACK;
            end
            ST_RACK: begin
               bit_cnt <= 3'd0;
               if (!sda_i) begin
                  state <= ST_RDATA;
                  tx_sh <= rdata;
                  ptr   <= ptr + 1'b1;
               end else begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // Program window after each commit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           busy_cnt <= '0;
      else if (mem_we)      busy_cnt <= BW'(BUSY_CYCLES);
      else if (busy)        busy_cnt <= busy_cnt - 1'b1;
   end

   // Level the slave wants on SDA for the bit that begins at this SCL fall
   always_comb begin
      case (state)
         ST_ACK_DEV, ST_ACK_WADDR, ST_ACK_WDATA: drive_next = 1'b1;
         ST_RDATA:                               drive_next = ~tx_sh[7];
         default:                                drive_next = 1'b0;
      endcase
   end

   if (HOLD_CYC == 0) begin : g_hold_none
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sda_oe_q <= 1'b0;
         else if (scl_fall) sda_oe_q <= drive_next;
      end
   end else begin : g_hold_cnt
      localparam int unsigned HW = $clog2(HOLD_CYC + 1);
      logic [HW-1:0] hcnt;
      logic          hpend;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hcnt     <= '0;
            hpend    <= 1'b0;
            sda_oe_q <= 1'b0;
         end else if (scl_fall) begin
            hcnt  <= HW'(HOLD_CYC);
            hpend <= drive_next;
         end else if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
            if (hcnt == HW'(1)) sda_oe_q <= hpend;
         end
      end
   end

   assign sda_oe_o   = sda_oe_q;
   assign csum_bad_o = csum_bad;
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe_o,
   input logic busy,
   input logic in_ack_dev,
   input logic stop_evt,
   input logic wp_i,
   input logic mem_we,
   input logic csum_bad_o,
   input logic scan_done
);
   // R11
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);

   // R9
   busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ack_dev);

   // R9
   commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);

   // R10
   wp_no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp_i && !busy) |=> !busy);

   // R12
   csum_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(csum_bad_o) |-> scan_done);
endmodule

bind spd_eeprom_slave spd_eeprom_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_i      (scl_i),
   .sda_oe_o   (sda_oe_o),
   .busy       (busy),
   .in_ack_dev (in_ack_dev),
   .stop_evt   (stop_evt),
   .wp_i       (wp_i),
   .mem_we     (mem_we),
   .csum_bad_o (csum_bad_o),
   .scan_done  (scan_done)
);

// File: tb/spd_eeprom_slave_tb.sv
module spd_eeprom_slave_tb;
   localparam int unsigned BUSY  = 3000;
   localparam int unsigned HOLD  = 4;
   localparam int unsigned Q     = 10;
   localparam logic [2:0]  STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   logic csum_bad;
   logic sda_bus;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [7:0] got [0:63];

   always #10 clk = ~clk;

   assign sda_bus = m_sda & ~sda_oe;

   spd_eeprom_slave #(.BUSY_CYCLES(BUSY), .HOLD_CYC(HOLD)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .sda_oe_o   (sda_oe),
      .strap_i    (STRAP),
      .wp_i       (wp),
      .csum_bad_o (csum_bad)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic put_bit(input logic b);
      tick(Q); m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_bus; tick(Q); scl = 1'b0;
   endtask

   task automatic bus_start;
      tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b0;
   endtask

   task automatic bus_stop;
      tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(a);
      acked = !a;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      logic v;
      for (int i = 7; i >= 0; i--) begin
         get_bit(v);
         b[i] = v;
      end
      put_bit(nack);
   endtask

   function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
      return {4'b1010, s, rd};
   endfunction

   // Random read of n bytes starting at addr into got[]; returns all acks seen
   task automatic read_block(input logic [7:0] addr, input int n, output logic ok);
      logic a0, a1, a2;
      logic [7:0] d;
      bus_start;
      send_byte(dev(STRAP, 1'b0), a0);
      send_byte(addr, a1);
      bus_start;
      send_byte(dev(STRAP, 1'b1), a2);
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n - 1, d);
         got[i] = d;
      end
      bus_stop;
      ok = a0 && a1 && a2;
   endtask

   task automatic write_one(input logic [7:0] addr, input logic [7:0] data, output logic ok);
      logic a0, a1, a2;
      bus_start;
      send_byte(dev(STRAP, 1'b0), a0);
      send_byte(addr, a1);
      send_byte(data, a2);
      bus_stop;
      ok = a0 && a1 && a2;
   endtask

   task automatic probe(output logic acked);
      bus_start;
      send_byte(dev(STRAP, 1'b0), acked);
      bus_stop;
   endtask

   task automatic t_reset;
      tick(100);
      chk(sda_oe == 1'b0, "R2 sda released after reset", sda_oe, 0);
      chk(csum_bad == 1'b0, "R12 flag low after reset scan", csum_bad, 0);
   endtask

   task automatic t_ident;
      logic ok;
      logic [7:0] d;
      logic a;
      read_block(8'h00, 1, ok);
      chk(ok, "R4 random read acks", ok, 1);
      chk(got[0] == 8'h80, "R2 byte 00h", got[0], 8'h80);
      // current-address read continues at byte 01h (R5)
      bus_start;
      send_byte(dev(STRAP, 1'b1), a);
      recv_byte(1'b1, d);
      bus_stop;
      chk(a && d == 8'h08, "R5 current-address read gives byte 01h", d, 8'h08);
   endtask

   task automatic t_blank;
      logic ok;
      read_block(8'h28, 1, ok);
      chk(got[0] == 8'h00, "R2 byte 28h blank", got[0], 0);
      read_block(8'hC8, 1, ok);
      chk(got[0] == 8'h00, "R2 byte C8h blank", got[0], 0);
   endtask

   task automatic t_checksum;
      logic ok;
      logic [7:0] sum;
      sum = 8'h00;
      read_block(8'h00, 64, ok);
      for (int i = 0; i < 63; i++) sum = sum + got[i];
      chk(ok && got[63] == sum, "R3 check byte equals sum", got[63], sum);
      chk(got[2] == 8'h07, "R5 sequential read byte 02h", got[2], 8'h07);
   endtask

   task automatic t_wrap;
      logic ok;
      read_block(8'hFF, 2, ok);
      chk(got[0] == 8'h00, "R5 byte FFh", got[0], 0);
      chk(got[1] == 8'h80, "R5 pointer wraps to 00h", got[1], 8'h80);
   endtask

   task automatic t_addr;
      logic a;
      bus_start;
      send_byte(dev(3'b010, 1'b0), a);
      bus_stop;
      chk(!a, "R1 other strap value not acknowledged", a, 0);
      bus_start;
      send_byte({4'b1011, STRAP, 1'b0}, a);
      bus_stop;
      chk(!a, "R1 other type nibble not acknowledged", a, 0);
      probe(a);
      chk(a, "R1 own address acknowledged", a, 1);
   endtask

   task automatic t_hold;
      logic a;
      bus_start;
      for (int i = 7; i >= 0; i--) put_bit(dev(STRAP, 1'b0)[i]);
      tick(2);
      chk(sda_oe == 1'b0, "R11 no drive before hold", sda_oe, 0);
      tick(HOLD);
      chk(sda_oe == 1'b1, "R11 ack drive after hold", sda_oe, 1);
      tick(Q - 2 - HOLD); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); a = sda_bus; tick(Q); scl = 1'b0;
      bus_stop;
      chk(a == 1'b0, "R11 ack seen on bus", a, 0);
   endtask

   task automatic t_write_busy;
      logic ok, a;
      write_one(8'h64, 8'hA5, ok);
      chk(ok, "R6 write acks", ok, 1);
      probe(a);
      chk(!a, "R9 address ignored in window", a, 0);
      tick(BUSY + 200);
      probe(a);
      chk(a, "R9 address answered after window", a, 1);
      read_block(8'h64, 1, ok);
      chk(got[0] == 8'hA5, "R6 byte stored", got[0], 8'hA5);
      chk(csum_bad == 1'b0, "R12 flag low after write outside sum", csum_bad, 0);
   endtask

   task automatic t_wp;
      logic ok, a;
      wp = 1'b1;
      write_one(8'h65, 8'h3C, ok);
      wp = 1'b0;
      chk(ok, "R10 protected write still acknowledged", ok, 1);
      probe(a);
      chk(a, "R10 no window after protected write", a, 1);
      read_block(8'h65, 1, ok);
      chk(got[0] == 8'h00, "R10 store unchanged", got[0], 0);
   endtask

   task automatic t_single;
      logic a0, a1, a2, a3, ok;
      bus_start;
      send_byte(dev(STRAP, 1'b0), a0);
      send_byte(8'h6E, a1);
      send_byte(8'h5A, a2);
      send_byte(8'hC3, a3);
      bus_stop;
      chk(a0 && a1 && a2, "R7 first data byte acknowledged", a2, 1);
      chk(!a3, "R7 second data byte not acknowledged", a3, 0);
      tick(BUSY + 200);
      read_block(8'h6E, 2, ok);
      chk(got[0] == 8'h5A, "R7 first byte stored", got[0], 8'h5A);
      chk(got[1] == 8'h00, "R7 second byte discarded", got[1], 0);
   endtask

   task automatic t_abort;
      logic a0, a1, a2, a3, ok;
      logic [7:0] d;
      bus_start;
      send_byte(dev(STRAP, 1'b0), a0);
      send_byte(8'h78, a1);
      send_byte(8'h77, a2);
      bus_start;
      send_byte(dev(STRAP, 1'b1), a3);
      recv_byte(1'b1, d);
      bus_stop;
      chk(a3, "R8 no window after abandoned write", a3, 1);
      read_block(8'h78, 1, ok);
      chk(got[0] == 8'h00, "R8 abandoned byte not stored", got[0], 0);
   endtask

   task automatic t_csum_flag;
      logic ok;
      logic [7:0] orig;
      read_block(8'h05, 1, ok);
      orig = got[0];
      write_one(8'h05, ~orig, ok);
      tick(BUSY + 200);
      chk(csum_bad == 1'b1, "R12 flag high after changing summed byte", csum_bad, 1);
      write_one(8'h05, orig, ok);
      tick(BUSY + 200);
      chk(csum_bad == 1'b0, "R12 flag low after restore", csum_bad, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      t_reset;
      t_ident;
      t_blank;
      t_checksum;
      t_wrap;
      t_addr;
      t_hold;
      t_write_busy;
      t_wp;
      t_single;
      t_abort;
      t_csum_flag;
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule